// File: doc/BRIEF.md
# Mailbox Transmit Cancel Controller

This block keeps the transmit-request state for sixteen message mailboxes in a CAN-style controller. Software raises a transmit request by writing 1 to a mailbox's bit in the pending register. It withdraws a request by writing 1 to the same bit of the cancel register. A frame engine reports three things through a small strobe interface: which mailbox has begun sending, and whether that send ended normally or with an error.

The block decides whether each withdrawal succeeds. A mailbox that is idle gives up its request at once and raises its abort-acknowledge flag. A mailbox that is already on the wire cannot be stopped. Its cancel bit then waits until the transmission ends. A normal end retires the request through the transmit-acknowledge flag. An error end hands the request back to the cancel logic, which then aborts it. Both acknowledge flags are cleared by writing 1 to them.

Register port map: address 0 is pending (write 1 to set, read back), address 1 is cancel, address 2 is abort-acknowledge, and address 3 is transmit-acknowledge. Reads are combinational from `cpu_addr`. Writes take effect at the clock edge.

Top module: `txcancel_ctrl`

## Requirements
- R1: Take a mailbox n in 1..15 that is a transmit mailbox, is pending, and is not transmitting. A 1 written to bit n at address 1 reads back as set for one cycle. On the next clock edge the cancel attempt completes.
- R2: Bit 0 of the cancel register at address 1 always reads 0, and writing 1 to it has no effect on any register.
- R3: After reset, the registers at addresses 0 to 3 all read 0.
- R4: A successful cancel clears the pending bit and the cancel bit of that mailbox, and sets its abort-acknowledge bit (address 2).
- R5: While mailbox n is transmitting, its cancel bit stays set and no abort acknowledge is raised. A normal end of that transmission clears the cancel bit.
- R6: Writing 0 to a pending bit does not clear it. Pending bits are cleared only by a successful cancel or by a normal end of transmission.
- R7: A 1 written to cancel bit n is ignored when `mbox_is_tx[n]` is 0.
- R8: A cancel bit set for a mailbox with no pending request is dropped on the next clock edge, and no abort acknowledge is raised.
- R9: A normal end (`fe_done` with `fe_idx`=n) clears pending bit n and sets transmit-acknowledge bit n (address 3). Writing 1 to a bit at address 2 or 3 clears it. If a clear and a set of the same bit happen in the same cycle, the set wins.
- R10: A cancel write and `fe_start` for the same mailbox in the same cycle are resolved in favour of the start, so the cancel waits as in R5.
- R11: An error end (`fe_err` with `fe_idx`=n) ends transmission without clearing pending bit n. A cancel bit still waiting on n then completes as an abort on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register select (0 pending, 1 cancel, 2 abort ack, 3 transmit ack) |
| cpu_wdata | input | 16 | Write data, one bit per mailbox |
| cpu_rdata | output | 16 | Read data of the selected register |
| mbox_is_tx | input | 16 | 1 marks a mailbox as configured for transmit |
| fe_start | input | 1 | Frame engine began sending mailbox `fe_idx` |
| fe_done | input | 1 | Frame engine finished mailbox `fe_idx` normally |
| fe_err | input | 1 | Frame engine ended mailbox `fe_idx` with an error |
| fe_idx | input | 4 | Mailbox number for the frame engine strobes |

## Verification
The bench targets four cases. The first is a cancel that lands on the same cycle as the start strobe; a design that let the cancel win here would raise an abort for a frame that is on the wire. The second is a cancel that waits through a transmission; this exposes a design that aborts early, or that leaves the cancel bit stuck after a normal end. The third is an error end behind a waiting cancel, which a design that never re-evaluates would leave hanging forever. The last covers writes to the reserved bit 0, to receive mailboxes and to idle mailboxes, where a loose write mask would produce spurious cancels or spurious abort acknowledges.

// File: rtl/txc_pkg.sv
// Shared definitions for the mailbox transmit cancel controller.
// Assumes a four-entry register map selected by a two-bit address.
package txc_pkg;

    typedef enum logic [1:0] {
        REG_PEND     = 2'd0,
        REG_CANCEL   = 2'd1,
        REG_ABORTACK = 2'd2,
        REG_TXACK    = 2'd3
    } txc_reg_e;

    // One mailbox's view of the frame-engine strobes.
    typedef struct packed {
        logic start;
        logic done;
        logic err;
    } fe_evt_t;

    // One mailbox's view of the software writes.
    typedef struct packed {
        logic pend_set;
        logic cancel_set;
        logic abort_clr;
        logic txack_clr;
    } cpu_wr_t;

endpackage

// File: rtl/txc_evt_decode.sv
// Turns the indexed frame-engine strobes into one event record per mailbox.
// Assumes at most one strobe kind is active per cycle for a given index;
// an index beyond NMB-1 matches no mailbox.
module txc_evt_decode
    import txc_pkg::*;
#(
    parameter int NMB   = 16,
    parameter int IDX_W = $clog2(NMB)
) (
    input  logic             fe_start,
    input  logic             fe_done,
    input  logic             fe_err,
    input  logic [IDX_W-1:0] fe_idx,
    output fe_evt_t          evt [NMB]
);

    for (genvar g = 0; g < NMB; g++) begin : g_dec
        logic hit;
        // Compare the strobe index against this mailbox number.
        always_comb begin
            hit = (fe_idx == IDX_W'(g));
        end
        // Qualify each strobe kind with the index match.
        always_comb begin
            evt[g].start = fe_start & hit;
            evt[g].done  = fe_done  & hit;
            evt[g].err   = fe_err   & hit;
        end
    end

endmodule

// File: rtl/txc_regport.sv
// Register port: decodes software writes into per-mailbox strobes and
// multiplexes the four state vectors onto the read bus.
// Assumes single-cycle writes; reads are combinational.
module txc_regport
    import txc_pkg::*;
#(
    parameter int NMB = 16
) (
    input  logic           cpu_we,
    input  logic [1:0]     cpu_addr,
    input  logic [NMB-1:0] cpu_wdata,
    input  logic [NMB-1:0] mbox_is_tx,
    input  logic [NMB-1:0] pend_vec,
    input  logic [NMB-1:0] cancel_vec,
    input  logic [NMB-1:0] abort_vec,
    input  logic [NMB-1:0] txack_vec,
    output cpu_wr_t        wr [NMB],
    output logic [NMB-1:0] cpu_rdata
);

    txc_reg_e sel;

    // Map the raw address onto the register enumeration.
    always_comb begin
        sel = txc_reg_e'(cpu_addr);
    end

    for (genvar g = 0; g < NMB; g++) begin : g_wr
        // Per-bit write strobes; cancel writes need a transmit mailbox.
        always_comb begin
            wr[g].pend_set   = cpu_we & (sel == REG_PEND)     & cpu_wdata[g];
            wr[g].cancel_set = cpu_we & (sel == REG_CANCEL)   & cpu_wdata[g] & mbox_is_tx[g];
            wr[g].abort_clr  = cpu_we & (sel == REG_ABORTACK) & cpu_wdata[g];
            wr[g].txack_clr  = cpu_we & (sel == REG_TXACK)    & cpu_wdata[g];
        end
    end

    // Read multiplexer over the four state vectors.
    always_comb begin
        unique case (sel)
            REG_PEND:     cpu_rdata = pend_vec;
            REG_CANCEL:   cpu_rdata = cancel_vec;
            REG_ABORTACK: cpu_rdata = abort_vec;
            REG_TXACK:    cpu_rdata = txack_vec;
            default:      cpu_rdata = '0;
        endcase
    end

endmodule

// File: rtl/txc_mbox_slice.sv
// State of one mailbox: pending, cancel request, in-transmission, and the
// two acknowledge flags. HAS_CANCEL=0 makes the cancel bit a reserved zero.
// Assumes the frame engine only ends a transmission it started.
module txc_mbox_slice
    import txc_pkg::*;
#(
    parameter bit HAS_CANCEL = 1'b1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  fe_evt_t evt,
    input  cpu_wr_t wr,
    output logic    pend_q,
    output logic    cancel_q,
    output logic    busy_q,
    output logic    abort_q,
    output logic    txack_q
);

    logic drop;
    logic abort;
    logic cancel_in;
    logic tx_end;

    // Resolve a held cancel request against the current mailbox state.
    always_comb begin
        drop      = cancel_q & ~pend_q;
        abort     = cancel_q & pend_q & ~busy_q & ~evt.start;
        cancel_in = wr.cancel_set & HAS_CANCEL;
        tx_end    = evt.done | evt.err;
    end

    // Pending request: set by software, cleared by abort or normal end.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q & ~abort & ~evt.done) | wr.pend_set;
    end

    // Cancel request: held until dropped, aborted or overtaken by completion.
    always_ff @(posedge clk) begin
        if (!rst_n) cancel_q <= 1'b0;
        else        cancel_q <= (cancel_q & ~(drop | abort | evt.done)) | cancel_in;
    end

    // In-transmission flag between start and either end strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= (busy_q & ~tx_end) | evt.start;
    end

    // Abort acknowledge: write-1-to-clear, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) abort_q <= 1'b0;
        else        abort_q <= (abort_q & ~wr.abort_clr) | abort;
    end

    // Transmit acknowledge: write-1-to-clear, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) txack_q <= 1'b0;
        else        txack_q <= (txack_q & ~wr.txack_clr) | evt.done;
    end

endmodule

// File: rtl/txcancel_ctrl.sv
// Top of the mailbox transmit cancel controller. Instantiates the strobe
// decoder, the register port and one state slice per mailbox. Mailbox 0
// has no cancel bit. Assumes one mailbox in transmission at a time.
module txcancel_ctrl
    import txc_pkg::*;
#(
    parameter  int NMB   = 16,
    localparam int IDX_W = $clog2(NMB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_we,
    input  logic [1:0]       cpu_addr,
    input  logic [NMB-1:0]   cpu_wdata,
    output logic [NMB-1:0]   cpu_rdata,
    input  logic [NMB-1:0]   mbox_is_tx,
    input  logic             fe_start,
    input  logic             fe_done,
    input  logic             fe_err,
    input  logic [IDX_W-1:0] fe_idx
);

    fe_evt_t        evt [NMB];
    cpu_wr_t        wr  [NMB];
    logic [NMB-1:0] pend_vec;
    logic [NMB-1:0] cancel_vec;
    logic [NMB-1:0] busy_vec;
    logic [NMB-1:0] abort_vec;
    logic [NMB-1:0] txack_vec;

    txc_evt_decode #(.NMB(NMB), .IDX_W(IDX_W)) dec_i (
        .fe_start (fe_start),
        .fe_done  (fe_done),
        .fe_err   (fe_err),
        .fe_idx   (fe_idx),
        .evt      (evt)
    );

    txc_regport #(.NMB(NMB)) port_i (
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .mbox_is_tx (mbox_is_tx),
        .pend_vec   (pend_vec),
        .cancel_vec (cancel_vec),
        .abort_vec  (abort_vec),
        .txack_vec  (txack_vec),
        .wr         (wr),
        .cpu_rdata  (cpu_rdata)
    );

    for (genvar g = 0; g < NMB; g++) begin : g_mb
        txc_mbox_slice #(.HAS_CANCEL(g != 0)) slice_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (evt[g]),
            .wr       (wr[g]),
            .pend_q   (pend_vec[g]),
            .cancel_q (cancel_vec[g]),
            .busy_q   (busy_vec[g]),
            .abort_q  (abort_vec[g]),
            .txack_q  (txack_vec[g])
        );
    end

endmodule

// File: rtl/txc_checker.sv
// Protocol checker for txcancel_ctrl, attached by bind below.
// Assumes synchronous active-low reset asserted from time zero.
module txc_checker #(
    parameter int NMB   = 16,
    parameter int IDX_W = $clog2(NMB)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fe_done,
    input logic             fe_err,
    input logic [IDX_W-1:0] fe_idx,
    input logic [NMB-1:0]   pend_vec,
    input logic [NMB-1:0]   cancel_vec,
    input logic [NMB-1:0]   busy_vec,
    input logic [NMB-1:0]   abort_vec,
    input logic [NMB-1:0]   txack_vec
);

    logic [NMB-1:0] end_1h;

    // One-hot of mailboxes whose transmission ends this cycle.
    always_comb begin
        end_1h = '0;
        for (int i = 0; i < NMB; i++) begin
            if ((fe_done || fe_err) && fe_idx == IDX_W'(i)) end_1h[i] = 1'b1;
        end
    end

    AST_CANCEL_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_vec[0] == 1'b0); // R2

    AST_NO_ABORT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((abort_vec & ~$past(abort_vec) & $past(busy_vec)) == '0)); // R5

    AST_ABORT_NEEDS_PENDING_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((abort_vec & ~$past(abort_vec) & ~$past(cancel_vec & pend_vec)) == '0)); // R8

    AST_WAITING_CANCEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(cancel_vec & busy_vec & ~end_1h) & ~cancel_vec) == '0)); // R10

    AST_TXACK_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fe_done && (int'(fe_idx) < NMB) |=> txack_vec[$past(fe_idx)]); // R9

endmodule

bind txcancel_ctrl txc_checker #(.NMB(NMB), .IDX_W(IDX_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fe_done    (fe_done),
    .fe_err     (fe_err),
    .fe_idx     (fe_idx),
    .pend_vec   (pend_vec),
    .cancel_vec (cancel_vec),
    .busy_vec   (busy_vec),
    .abort_vec  (abort_vec),
    .txack_vec  (txack_vec)
);

// File: tb/txcancel_ctrl_tb_top.sv
`timescale 1ns/1ps
module txcancel_ctrl_tb_top;

    localparam int NMB = 16;
    localparam logic [15:0] IS_TX = 16'hFFDF; // mailbox 5 is receive-only

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        fe_start = 1'b0, fe_done = 1'b0, fe_err = 1'b0;
    logic [3:0]  fe_idx = '0;

    int vectors = 0;
    int miscomp = 0;
    bit finished = 1'b0;

    // Bench-side expectation state
    logic [15:0] m_pend = '0, m_cancel = '0, m_busy = '0, m_abort = '0, m_txack = '0;

    always #10 clk = ~clk; // 50 MHz

    txcancel_ctrl #(.NMB(NMB)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .mbox_is_tx(IS_TX),
        .fe_start(fe_start), .fe_done(fe_done), .fe_err(fe_err), .fe_idx(fe_idx)
    );

    function automatic logic [15:0] exp_reg(logic [1:0] a);
        case (a)
            2'd0:    return m_pend;
            2'd1:    return m_cancel;
            2'd2:    return m_abort;
            default: return m_txack;
        endcase
    endfunction

    // Expected state after the next edge, from the requirement rules.
    task automatic model_step(output logic [15:0] np, nc, nb, na, nt);
        np = m_pend; nc = m_cancel; nb = m_busy; na = m_abort; nt = m_txack;
        for (int n = 0; n < NMB; n++) begin
            bit st = fe_start && fe_idx == 4'(n);
            bit dn = fe_done  && fe_idx == 4'(n);
            bit er = fe_err   && fe_idx == 4'(n);
            bit drop  = m_cancel[n] && !m_pend[n];                     // R8
            bit abrt  = m_cancel[n] && m_pend[n] && !m_busy[n] && !st; // R4 R10
            np[n] = (m_pend[n] && !abrt && !dn) || (cpu_we && cpu_addr == 2'd0 && cpu_wdata[n]);
            nc[n] = (m_cancel[n] && !(drop || abrt || dn)) ||
                    (cpu_we && cpu_addr == 2'd1 && cpu_wdata[n] && IS_TX[n] && n != 0); // R2 R7
            nb[n] = (m_busy[n] && !(dn || er)) || st;
            na[n] = (m_abort[n] && !(cpu_we && cpu_addr == 2'd2 && cpu_wdata[n])) || abrt;
            nt[n] = (m_txack[n] && !(cpu_we && cpu_addr == 2'd3 && cpu_wdata[n])) || dn; // R9
        end
    endtask

    // One cycle: drive at negedge, compare read data, advance expectations.
    task automatic cyc(bit we, logic [1:0] a, logic [15:0] d, bit st, bit dn, bit er,
                       logic [3:0] ix, string tag, bit use_lit = 1'b0, logic [15:0] lit = '0);
        logic [15:0] np, nc, nb, na, nt, ev;
        @(negedge clk);
        cpu_we = we; cpu_addr = a; cpu_wdata = d;
        fe_start = st; fe_done = dn; fe_err = er; fe_idx = ix;
        #1;
        ev = use_lit ? lit : exp_reg(a);
        vectors++;
        if (cpu_rdata !== ev) begin
            miscomp++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, cpu_rdata, ev);
        end
        if (use_lit && lit !== exp_reg(a)) begin
            miscomp++;
            $display("FAIL %s bench expectation mismatch actual=%h expected=%h", tag, exp_reg(a), lit);
        end
        model_step(np, nc, nb, na, nt);
        @(posedge clk);
        m_pend = np; m_cancel = nc; m_busy = nb; m_abort = na; m_txack = nt;
    endtask

    task automatic rd(logic [1:0] a, logic [15:0] lit, string tag);
        cyc(1'b0, a, '0, 1'b0, 1'b0, 1'b0, '0, tag, 1'b1, lit);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d, string tag);
        cyc(1'b1, a, d, 1'b0, 1'b0, 1'b0, '0, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscomp++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R3 reset values
        rd(2'd0, 16'h0000, "R3 pend");
        rd(2'd1, 16'h0000, "R3 cancel");
        rd(2'd2, 16'h0000, "R3 abort");
        rd(2'd3, 16'h0000, "R3 txack");

        // R1 / R4 successful cancel of idle mailbox 3
        wr(2'd0, 16'h0008, "R1 set pend");
        wr(2'd1, 16'h0008, "R1 cancel");
        rd(2'd1, 16'h0008, "R1 cancel visible");
        rd(2'd0, 16'h0000, "R4 pend cleared");
        rd(2'd2, 16'h0008, "R4 abort ack");
        rd(2'd1, 16'h0000, "R4 cancel cleared");

        // R2 reserved bit 0, R8 idle mailboxes dropped
        wr(2'd0, 16'h0001, "R2 set pend0");
        wr(2'd1, 16'hFFFF, "R2 cancel all");
        rd(2'd1, 16'hFFDE, "R2 bit0 reads 0");
        rd(2'd1, 16'h0000, "R8 dropped");
        rd(2'd0, 16'h0001, "R2 pend0 kept");
        rd(2'd2, 16'h0008, "R8 no new abort");

        // R6 writing 0 does not clear
        wr(2'd0, 16'h0000, "R6 write zero");
        rd(2'd0, 16'h0001, "R6 pend kept");

        // R7 receive mailbox ignores cancel
        wr(2'd0, 16'h0020, "R7 set pend5");
        wr(2'd1, 16'h0020, "R7 cancel5");
        rd(2'd1, 16'h0000, "R7 cancel ignored");
        rd(2'd0, 16'h0021, "R7 pend kept");

        // R9 write-1-to-clear abort ack
        wr(2'd2, 16'h0008, "R9 clear abort");
        rd(2'd2, 16'h0000, "R9 abort cleared");

        // R5 cancel waits for transmission
        wr(2'd0, 16'h0004, "R5 set pend2");
        cyc(1'b0, 2'd1, '0, 1'b1, 1'b0, 1'b0, 4'd2, "R5 start");
        wr(2'd1, 16'h0004, "R5 cancel2");
        for (int k = 0; k < 3; k++) rd(2'd1, 16'h0004, "R5 cancel waits");
        rd(2'd2, 16'h0000, "R5 no abort");
        cyc(1'b0, 2'd1, '0, 1'b0, 1'b1, 1'b0, 4'd2, "R5 done");
        rd(2'd1, 16'h0000, "R5 cancel cleared by done");
        rd(2'd3, 16'h0004, "R9 txack set");
        rd(2'd0, 16'h0021, "R9 pend cleared");

        // R10 cancel and start in same cycle
        wr(2'd0, 16'h0200, "R10 set pend9");
        cyc(1'b1, 2'd1, 16'h0200, 1'b1, 1'b0, 1'b0, 4'd9, "R10 cancel+start");
        rd(2'd1, 16'h0200, "R10 cancel waits");
        rd(2'd2, 16'h0000, "R10 no abort");
        cyc(1'b0, 2'd1, '0, 1'b0, 1'b1, 1'b0, 4'd9, "R10 done");
        rd(2'd3, 16'h0204, "R10 txack");
        rd(2'd2, 16'h0000, "R10 still no abort");

        // R11 error end re-evaluates waiting cancel
        wr(2'd0, 16'h0800, "R11 set pend11");
        cyc(1'b0, 2'd1, '0, 1'b1, 1'b0, 1'b0, 4'd11, "R11 start");
        wr(2'd1, 16'h0800, "R11 cancel11");
        rd(2'd1, 16'h0800, "R11 waiting");
        cyc(1'b0, 2'd1, '0, 1'b0, 1'b0, 1'b1, 4'd11, "R11 error end");
        rd(2'd1, 16'h0800, "R11 still held after error");
        rd(2'd2, 16'h0800, "R11 abort after error");
        rd(2'd0, 16'h0021, "R11 pend cleared by abort");

        // R9 txack clear
        wr(2'd3, 16'hFFFF, "R9 clear txack");
        rd(2'd3, 16'h0000, "R9 txack cleared");

        // Constrained random phase
        for (int c = 0; c < 4000; c++) begin
            bit we = ($urandom % 2) == 0;
            logic [1:0] a = 2'($urandom % 4);
            logic [15:0] d = 16'($urandom & $urandom);
            bit st = 1'b0, dn = 1'b0, er = 1'b0;
            logic [3:0] ix = 4'($urandom % 16);
            if (m_busy == '0) begin
                if (m_pend[ix] && ($urandom % 3) == 0) st = 1'b1;
            end else begin
                for (int n = 0; n < NMB; n++) if (m_busy[n]) ix = 4'(n);
                if (($urandom % 6) == 0) begin
                    if (($urandom % 4) == 0) er = 1'b1; else dn = 1'b1;
                end
            end
            cyc(we, a, d, st, dn, er, ix, "RND R1 R4 R5 R8 R9 R11");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

endmodule